// File: doc/BRIEF.md
# Asynchronous Serial Transceiver Core

This block is a byte-wide, host-programmed serial transmitter and receiver for asynchronous framing. A host reaches it through an active-low chip select, active-low read and write strobes and one register-select line. These give access to a configuration word, a run-control word, a status byte, a transmit buffer and a receive buffer. Each character carries a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one or two high stop bits.

The bus clock times only the host side. Serial bit timing comes from two enables, one for transmit and one for receive. Each enable pulses at 16 times the bit rate. The transmitter holds one character waiting behind the character being shifted out. The receiver qualifies a start edge at mid-bit, assembles the character and flags parity, framing and overrun errors. It also reports a line held low for longer than two whole characters.

The host port has no back-pressure. The host must poll TxRDY before it writes a character and RxRDY before it reads one. A character written while the transmit buffer is occupied is dropped. Each bus clock cycle with chip select and a strobe low counts as one access.

Top module: `sa_uart_core`

## Requirements
- R1: With `sel_ctl`=1, a write goes to the control path and a read returns the status byte. With `sel_ctl`=0, a write loads the transmit buffer and a read returns the receive buffer.
- R2: After reset the status byte reads 0x05, `txd` is high, and the next control write is taken as the configuration word. Status bits: 0 TxRDY, 1 RxRDY, 2 TxEMPTY, 3 parity error, 4 overrun, 5 framing error, 6 break, 7 zero.
- R3: The first control write after reset is the configuration word: bits 1:0 give the data length (00 gives 5 bits, 11 gives 8), bit 2 enables parity, bit 3 selects even parity (0 = odd), bit 4 selects two stop bits. Every later control write is a run-control word: bit 0 enables transmit, bit 1 enables receive, bit 2 clears the error flags. Nothing is sent while transmit is disabled.
- R4: A transmitted frame is a 0 start bit, the data bits LSB first, the parity bit if enabled (even: total count of ones is even), then the stop bits as 1. Every bit lasts 16 transmit-enable pulses. The start bit appears on the cycle after a buffered character is moved into the shifter.
- R5: TxRDY is high while the transmit buffer is empty. TxEMPTY is high while the shifter is idle. A data write while the buffer is occupied is ignored.
- R6: After `rxd` falls, the receiver samples it again on the 8th receive pulse. If the line is high by then, the edge is discarded and no character results.
- R7: After the sample taken in the middle of the first stop bit, the character goes to the receive buffer and RxRDY rises. A data read clears RxRDY.
- R8: The parity error flag is set when the received parity bit disagrees with the configured parity. The framing error flag is set when the first stop bit is sampled low.
- R9: If a character completes while RxRDY is still set, the overrun flag is set and the buffer takes the newer character.
- R10: A run-control word with bit 2 set clears the parity, overrun and framing flags.
- R11: The break flag rises once `rxd` has been low for more than 2 x frame-bits x 16 receive pulses without a break, and it falls on the cycle after `rxd` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel_ctl | input | 1 | 1 selects control/status, 0 selects data |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (status or receive buffer) |
| tx_tick | input | 1 | Transmit enable, 16 pulses per bit |
| rx_tick | input | 1 | Receive enable, 16 pulses per bit |
| rxd | input | 1 | Serial input, idles high |
| txd | output | 1 | Serial output, idles high |
| tx_rdy | output | 1 | Transmit buffer empty |
| tx_empty | output | 1 | Transmit shifter idle |
| rx_rdy | output | 1 | Receive buffer holds an unread character |
| brk_det | output | 1 | Break condition on `rxd` |

## Verification
The bench writes a character on the cycle the buffer drains into the shifter, and another while the buffer is occupied. A design that let such a write overwrite the pending byte would put a different character on `txd`. A short low glitch on `rxd` checks the mid-bit start test: a receiver without it would deliver a spurious character. The bench sends back-to-back characters without reading, wrong parity and a low stop bit, and each case targets its own status bit. A break is timed either side of the 2-character threshold, so an off-by-a-character limit shows up.

// File: rtl/sa_uart_pkg.sv
package sa_uart_pkg;

  // Configuration word fields, packed so wdata[4:0] casts straight in
  typedef struct packed {
    logic       two_stop;
    logic       even;
    logic       par_en;
    logic [1:0] len;
  } mode_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;

  function automatic logic [3:0] data_bits(mode_t m);
    return 4'd5 + {2'b00, m.len};
  endfunction

  function automatic logic [3:0] frame_bits(mode_t m);
    return 4'd1 + data_bits(m) + {3'b000, m.par_en} + (m.two_stop ? 4'd2 : 4'd1);
  endfunction

endpackage

// File: rtl/sa_uart_regs.sv
module sa_uart_regs
  import sa_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       sel_ctl,
  input  logic [7:0] wdata,
  output mode_t      mode,
  output logic       tx_en,
  output logic       rx_en,
  output logic       err_clr,
  output logic       data_wr,
  output logic       data_rd
);
  logic mode_set;
  logic ctl_wr;

  assign ctl_wr  = ~cs_n & ~wr_n & sel_ctl;
  assign data_wr = ~cs_n & ~wr_n & ~sel_ctl;
  assign data_rd = ~cs_n & ~rd_n & ~sel_ctl;
  assign err_clr = ctl_wr & mode_set & wdata[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_set <= 1'b0;
      mode     <= '0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
    end else if (ctl_wr) begin
      if (!mode_set) begin
        mode     <= mode_t'(wdata[4:0]);
        mode_set <= 1'b1;
      end else begin
        tx_en <= wdata[0];
        rx_en <= wdata[1];
      end
    end
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (mode_set && ctl_wr) |=> $stable(mode)); // R3
  AST_FIRST_CTL_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    (!mode_set && ctl_wr) |=> (!tx_en && !rx_en)); // R3

endmodule

// File: rtl/sa_uart_tx.sv
module sa_uart_tx
  import sa_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  mode_t      mode,
  input  logic       tx_en,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       rdy,
  output logic       empty
);
  localparam int CW = $clog2(OVS);
  localparam int FW = 12;

  logic [7:0]    hold;
  logic          full;
  logic [FW-1:0] sh;
  logic [FW-1:0] fr;
  logic [3:0]    left;
  logic [3:0]    nb;
  logic          busy;
  logic          load;
  logic          par;
  logic [CW-1:0] tcnt;

  assign load = full && !busy && tx_en;

  // Frame image, LSB is sent first; unused upper positions stay high (stop)
  always_comb begin
    nb    = data_bits(mode);
    fr    = '1;
    fr[0] = 1'b0;
    par   = ~mode.even;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(nb)) begin
        fr[i+1] = hold[i];
        par     = par ^ hold[i];
      end
    end
    if (mode.par_en) fr[int'(nb)+1] = par;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      full <= 1'b0;
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
      tcnt <= '0;
    end else begin
      if (load) begin
        sh   <= fr;
        left <= frame_bits(mode);
        busy <= 1'b1;
        tcnt <= '0;
        full <= 1'b0;
      end else if (busy && tick) begin
        if (tcnt == CW'(OVS-1)) begin
          tcnt <= '0;
          sh   <= {1'b1, sh[FW-1:1]};
          left <= left - 4'd1;
          if (left == 4'd1) busy <= 1'b0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
      if (wr_stb && !full) begin
        hold <= wr_data;
        full <= 1'b1;
      end
    end
  end

  assign txd   = busy ? sh[0] : 1'b1;
  assign rdy   = !full;
  assign empty = !busy;

  AST_LOAD_FREES_BUF: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !full); // R5
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (full && wr_stb) |=> $stable(hold)); // R5
  AST_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(txd)); // R4

endmodule

// File: rtl/sa_uart_rx.sv
module sa_uart_rx
  import sa_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  mode_t      mode,
  input  logic       rx_en,
  input  logic       rd_stb,
  input  logic       err_clr,
  output logic [7:0] data,
  output logic       rdy,
  output logic       pe,
  output logic       oe,
  output logic       fe,
  output logic       brk
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int BW   = $clog2(24*OVS + 2);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [3:0]    nb;
  logic [3:0]    last;
  logic [7:0]    sh;
  logic          pbit;
  logic          mid;
  logic          done;
  logic          exp_p;
  logic [BW-1:0] lcnt;
  logic [BW-1:0] lim;

  assign nb    = data_bits(mode);
  assign last  = nb - 4'd1 + {3'b000, mode.par_en};
  assign mid   = tick && (cnt == CW'(OVS-1));
  assign done  = (st == RX_STOP) && mid;
  assign exp_p = (^sh) ^ ~mode.even;
  assign lim   = BW'(frame_bits(mode)) * BW'(2*OVS);
  assign brk   = lcnt > lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else begin
      case (st)
        RX_IDLE: if (rx_en && !rxd) begin
          st  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (tick) begin
          if (cnt == CW'(HALF-1)) begin
            cnt <= '0;
            if (rxd) st <= RX_IDLE;
            else begin
              st  <= RX_BITS;
              idx <= '0;
              sh  <= '0;
            end
          end else cnt <= cnt + 1'b1;
        end
        RX_BITS: if (tick) begin
          if (mid) begin
            cnt <= '0;
            if (idx < nb) sh[idx[2:0]] <= rxd;
            else          pbit         <= rxd;
            idx <= idx + 4'd1;
            if (idx == last) st <= RX_STOP;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (mid) begin
            cnt <= '0;
            st  <= RX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      rdy  <= 1'b0;
      pe   <= 1'b0;
      oe   <= 1'b0;
      fe   <= 1'b0;
    end else begin
      if (rd_stb) rdy <= 1'b0;
      if (err_clr) begin
        pe <= 1'b0;
        oe <= 1'b0;
        fe <= 1'b0;
      end
      if (done) begin
        data <= sh;
        rdy  <= 1'b1;
        if (rdy) oe <= 1'b1;
        if (!rxd) fe <= 1'b1;
        if (mode.par_en && (pbit != exp_p)) pe <= 1'b1;
      end
    end
  end

  // Low-time counter for break, saturating one past the limit
  always_ff @(posedge clk) begin
    if (rst || rxd)             lcnt <= '0;
    else if (tick && lcnt <= lim) lcnt <= lcnt + 1'b1;
  end

  AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
    (st == RX_START && tick && cnt == CW'(HALF-1) && rxd) |=> (st == RX_IDLE)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !done) |=> !rdy); // R7
  AST_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (done && rdy) |=> oe); // R9
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !done) |=> !(pe || oe || fe)); // R10
  AST_BRK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    rxd |=> !brk); // R11

endmodule

// File: rtl/sa_uart_core.sv
module sa_uart_core
  import sa_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       sel_ctl,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tx_tick,
  input  logic       rx_tick,
  input  logic       rxd,
  output logic       txd,
  output logic       tx_rdy,
  output logic       tx_empty,
  output logic       rx_rdy,
  output logic       brk_det
);
  mode_t      mode;
  logic       tx_en, rx_en, err_clr, data_wr, data_rd;
  logic       pe, oe, fe;
  logic [7:0] rx_data;
  logic [7:0] status;

  sa_uart_regs u_regs (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .sel_ctl(sel_ctl), .wdata(wdata), .mode(mode), .tx_en(tx_en),
    .rx_en(rx_en), .err_clr(err_clr), .data_wr(data_wr), .data_rd(data_rd)
  );

  sa_uart_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tx_tick), .mode(mode), .tx_en(tx_en),
    .wr_stb(data_wr), .wr_data(wdata), .txd(txd), .rdy(tx_rdy),
    .empty(tx_empty)
  );

  sa_uart_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(rx_tick), .rxd(rxd), .mode(mode),
    .rx_en(rx_en), .rd_stb(data_rd), .err_clr(err_clr), .data(rx_data),
    .rdy(rx_rdy), .pe(pe), .oe(oe), .fe(fe), .brk(brk_det)
  );

  assign status = {1'b0, brk_det, fe, oe, pe, tx_empty, rx_rdy, tx_rdy};
  assign rdata  = sel_ctl ? status : rx_data;

endmodule

// File: tb/sa_uart_core_tb.sv
module sa_uart_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel_ctl = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_tick = 1'b0, rx_tick = 1'b1, rxd = 1'b1;
  logic       txd, tx_rdy, tx_empty, rx_rdy, brk_det;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  sa_uart_core dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .sel_ctl(sel_ctl), .wdata(wdata), .rdata(rdata), .tx_tick(tx_tick),
    .rx_tick(rx_tick), .rxd(rxd), .txd(txd), .tx_rdy(tx_rdy),
    .tx_empty(tx_empty), .rx_rdy(rx_rdy), .brk_det(brk_det)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(negedge clk) tx_tick <= ~tx_tick;

  // ---------------- transmit reference model ----------------
  bit m_set, m_txen, m_full, m_busy;
  int m_nb, m_tc;
  bit m_par, m_even, m_two;
  logic [7:0] m_hold;
  bit m_q[$];

  always @(posedge clk) begin
    bit ctl, dw, full_old, p;
    ctl = !cs_n && !wr_n && sel_ctl;
    dw  = !cs_n && !wr_n && !sel_ctl;
    if (rst) begin
      m_set = 0; m_txen = 0; m_full = 0; m_busy = 0; m_tc = 0;
      m_nb = 5; m_par = 0; m_even = 0; m_two = 0; m_q.delete();
    end else begin
      full_old = m_full;
      if (m_full && !m_busy && m_txen) begin
        m_q.delete();
        m_q.push_back(1'b0);
        p = !m_even;
        for (int i = 0; i < m_nb; i++) begin
          m_q.push_back(m_hold[i]);
          p = p ^ m_hold[i];
        end
        if (m_par) m_q.push_back(p);
        m_q.push_back(1'b1);
        if (m_two) m_q.push_back(1'b1);
        m_busy = 1; m_tc = 0; m_full = 0;
      end else if (m_busy && tx_tick) begin
        if (m_tc == 15) begin
          m_tc = 0;
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_busy = 0;
        end else m_tc++;
      end
      if (dw && !full_old) begin
        m_hold = wdata; m_full = 1;
      end
      if (ctl) begin
        if (!m_set) begin
          m_set = 1; m_nb = 5 + int'(wdata[1:0]);
          m_par = wdata[2]; m_even = wdata[3]; m_two = wdata[4];
        end else m_txen = wdata[0];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit etx;
      etx = m_busy ? m_q[0] : 1'b1;
      n_cmp++;
      if (txd !== etx) begin
        n_bad++;
        $display("FAIL R4 txd at cycle %0d: actual %b expected %b", cyc, txd, etx);
      end
      n_cmp++;
      if ({tx_rdy, tx_empty} !== {!m_full, !m_busy}) begin
        n_bad++;
        $display("FAIL R5 tx_rdy/tx_empty at cycle %0d: actual %b%b expected %b%b",
                 cyc, tx_rdy, tx_empty, !m_full, !m_busy);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic [7:0] v);
    @(negedge clk); cs_n = 0; wr_n = 0; sel_ctl = c; wdata = v;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic bus_rd(input logic c, output logic [7:0] v);
    @(negedge clk); cs_n = 0; rd_n = 0; sel_ctl = c;
    #1 v = rdata;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic rx_bit(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input int nb, input bit usep,
                         input logic p, input logic stopv);
    @(negedge clk);
    rx_bit(1'b0, 16);
    for (int i = 0; i < nb; i++) rx_bit(d[i], 16);
    if (usep) rx_bit(p, 16);
    rx_bit(stopv, stopv ? 16 : 10);
    rx_bit(1'b1, 40);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk); rst = 0;
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] v;
    do_reset();
    bus_rd(1'b1, v);  chk("R2/R1 status after reset", v, 8'h05);
    chk("R2 txd idle", {7'b0, txd}, 8'h01);

    // 8 data bits, no parity, 1 stop; transmit and receive enabled
    bus_wr(1'b1, 8'h03);
    bus_wr(1'b1, 8'h03);
    bus_wr(1'b0, 8'hA5);
    repeat (2) @(negedge clk);
    bus_wr(1'b0, 8'h3C);          // buffered behind the first
    bus_wr(1'b0, 8'hC3);          // buffer occupied: dropped (R5)
    bus_rd(1'b1, v);  chk("R5 buffer and shifter both busy", v, 8'h00);
    repeat (1200) @(negedge clk);
    bus_rd(1'b1, v);  chk("R4 transmitter idle after frames", v, 8'h05);

    // receive path
    send_rx(8'h5A, 8, 0, 1'b0, 1'b1);
    bus_rd(1'b1, v);  chk("R7 RxRDY after character", v, 8'h07);
    bus_rd(1'b0, v);  chk("R7/R1 received data", v, 8'h5A);
    bus_rd(1'b1, v);  chk("R7 RxRDY cleared by read", v, 8'h05);

    // glitch shorter than half a bit
    @(negedge clk); rx_bit(1'b0, 4); rx_bit(1'b1, 300);
    bus_rd(1'b1, v);  chk("R6 glitch discarded", v, 8'h05);

    // overrun
    send_rx(8'h11, 8, 0, 1'b0, 1'b1);
    send_rx(8'h22, 8, 0, 1'b0, 1'b1);
    bus_rd(1'b1, v);  chk("R9 overrun flagged", v, 8'h17);
    bus_rd(1'b0, v);  chk("R9 newer character kept", v, 8'h22);
    bus_wr(1'b1, 8'h07);
    bus_rd(1'b1, v);  chk("R10 overrun cleared", v, 8'h05);

    // 7 data bits, even parity, 2 stop bits; receive only at first
    do_reset();
    bus_rd(1'b1, v);  chk("R2 status after second reset", v, 8'h05);
    bus_wr(1'b1, 8'h1E);
    bus_wr(1'b1, 8'h02);
    bus_wr(1'b0, 8'h41);
    repeat (200) @(negedge clk);
    bus_rd(1'b1, v);  chk("R3 held while transmit disabled", v, 8'h04);
    bus_wr(1'b1, 8'h03);
    repeat (500) @(negedge clk);
    bus_rd(1'b1, v);  chk("R4 7E2 frame sent", v, 8'h05);

    send_rx(8'h41, 7, 1, 1'b0, 1'b1);
    bus_rd(1'b1, v);  chk("R8 good parity", v, 8'h07);
    bus_rd(1'b0, v);  chk("R8 7-bit data", v, 8'h41);
    send_rx(8'h41, 7, 1, 1'b1, 1'b1);
    bus_rd(1'b1, v);  chk("R8 parity error", v, 8'h0F);
    bus_rd(1'b0, v);
    bus_wr(1'b1, 8'h07);
    bus_rd(1'b1, v);  chk("R10 parity error cleared", v, 8'h05);
    send_rx(8'h41, 7, 1, 1'b0, 1'b0);
    bus_rd(1'b1, v);  chk("R8 framing error", v, 8'h27);
    bus_rd(1'b0, v);
    bus_wr(1'b1, 8'h07);

    // break: 11-bit frame gives a 352-pulse limit
    @(negedge clk); rxd = 1'b0;
    repeat (345) @(negedge clk);
    chk("R11 no break below limit", {7'b0, brk_det}, 8'h00);
    repeat (15) @(negedge clk);
    chk("R11 break above limit", {7'b0, brk_det}, 8'h01);
    bus_rd(1'b1, v);  chk("R11 break status bit", v & 8'h40, 8'h40);
    rxd = 1'b1;
    @(negedge clk);
    chk("R11 break released", {7'b0, brk_det}, 8'h00);
    repeat (40) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule